// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This block rearranges the elements of one vector register under control of a per-element mask. In compress mode it gathers the elements whose mask bit is set and packs them, in rising source order, into the low slots of the output, zero-filling everything above them. In expand mode it does the reverse. It deals the low elements of the source, one by one, into the slots whose mask bit is set. Every other slot keeps the value supplied on the destination input.

A caller presents the mask, source vector, prior destination vector and mode, then pulses `start`. The unit samples all of these on that edge and walks the mask one bit per clock for exactly N cycles, regardless of how many bits are set. When it finishes, it pulses `done` for one cycle. At that point `result` holds the rearranged vector and `count` holds the number of set mask bits, which is the packed length. Both outputs hold their values until the next accepted start.

Top module: `vmce_unit`

## Requirements
- R1: After reset, `busy`, `done`, `count` and every bit of `result` are 0.
- R2: With `mode` = 0 (compress), output slot j holds the source element at the position of the (j+1)-th set mask bit, counting from bit 0 upward.
- R3: With `mode` = 0, every output slot at index ≥ popcount(mask) is zero.
- R4: When `done` is high, `count` equals the number of set bits in the mask sampled at start, in either mode.
- R5: With `mode` = 1 (expand), the output slot at the position of the (k+1)-th set mask bit holds source element k.
- R6: With `mode` = 1, every output slot whose mask bit is 0 equals the corresponding element of `dst_in` sampled at start.
- R7: `busy` is high for exactly N cycles after the accepting edge, whatever the mask. `done` is a one-cycle pulse in the cycle after `busy` falls and is never high together with `busy`.
- R8: A `start` pulse while `busy` is high is ignored, and so are changes to `mode`, `mask_in`, `src_in` or `dst_in` during a run. `result` stays unchanged from completion until the next accepted start.
- R9: An all-zero mask gives `count` 0, with an all-zero result in compress mode and `result` = `dst_in` in expand mode. An all-ones mask makes either mode a copy of `src_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0 = compress, 1 = expand; sampled at start |
| mask_in | input | N | One select bit per element, bit i for element i |
| src_in | input | N*W | Source vector, element i at bits [i*W +: W] |
| dst_in | input | N*W | Prior destination contents used by expand |
| busy | output | 1 | High while the mask is being scanned |
| done | output | 1 | One-cycle completion pulse |
| count | output | $clog2(N+1) | Number of set mask bits (packed length) |
| result | output | N*W | Rearranged vector, element i at bits [i*W +: W] |

## Verification
The bench builds the unit with N = 6 elements of 12 bits. Because six is not a power of two, the scan counter has to stop at N-1 rather than at a natural wrap. The `count` field also has to reach its top value of 6 with all-ones masks. Short elements keep random data readable while still filling several bits per slot. Random masks cover every packed length from 0 to 6 across both modes. Directed runs cover empty, full and single-top-bit masks, plus a start pulse with altered inputs partway through a run.

// File: rtl/vmce_pkg.sv
package vmce_pkg;

   typedef enum logic {
      VM_PACK   = 1'b0,
      VM_UNPACK = 1'b1
   } vm_mode_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int unsigned len_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/vmce_seq.sv
module vmce_seq
   import vmce_pkg::*;
#(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = idx_bits(N),
   parameter int unsigned CW = len_bits(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          mode_in,
   input  logic [N-1:0]  mask_in,
   output logic          load,
   output logic          busy,
   output logic          done,
   output logic          step_en,
   output logic [IW-1:0] rd_idx,
   output logic [IW-1:0] wr_idx,
   output logic [CW-1:0] count
);

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   vm_mode_e      mode_q;
   logic [N-1:0]  mask_q;
   logic [IW-1:0] scan_idx;
   logic [CW-1:0] fill_ptr;
   logic [IW-1:0] fill_idx;

   assign load     = start && !busy;
   assign step_en  = busy && mask_q[scan_idx];
   assign fill_idx = IW'(fill_ptr);
   assign count    = fill_ptr;

   always_comb begin
      if (mode_q == VM_UNPACK) begin
         rd_idx = fill_idx;
         wr_idx = scan_idx;
      end else begin
         rd_idx = scan_idx;
         wr_idx = fill_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         mode_q   <= VM_PACK;
         mask_q   <= '0;
         scan_idx <= '0;
         fill_ptr <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy     <= 1'b1;
            mode_q   <= vm_mode_e'(mode_in);
            mask_q   <= mask_in;
            scan_idx <= '0;
            fill_ptr <= '0;
         end else if (busy) begin
            if (mask_q[scan_idx]) begin
               fill_ptr <= fill_ptr + 1'b1;
            end
            if (scan_idx == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               scan_idx <= scan_idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/vmce_store.sv
module vmce_store
   import vmce_pkg::*;
#(
   parameter int unsigned N  = 8,
   parameter int unsigned W  = 64,
   parameter int unsigned IW = idx_bits(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           mode_in,
   input  logic [N*W-1:0] src_in,
   input  logic [N*W-1:0] dst_in,
   input  logic           step_en,
   input  logic [IW-1:0]  rd_idx,
   input  logic [IW-1:0]  wr_idx,
   output logic [N*W-1:0] result
);

   logic [W-1:0] src_q [N];
   logic [W-1:0] res_q [N];
   logic [W-1:0] pick;

   always_comb begin
      pick = src_q[rd_idx];
   end

   for (genvar e = 0; e < N; e++) begin : g_slot
      logic hit;
      assign hit = step_en && (wr_idx == IW'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q[e] <= '0;
            res_q[e] <= '0;
         end else if (load) begin
            src_q[e] <= src_in[e*W +: W];
            res_q[e] <= (vm_mode_e'(mode_in) == VM_UNPACK) ? dst_in[e*W +: W] : '0;
         end else if (hit) begin
            res_q[e] <= pick;
         end
      end

      assign result[e*W +: W] = res_q[e];
   end

endmodule

// File: rtl/vmce_unit.sv
module vmce_unit
   import vmce_pkg::*;
#(
   parameter int unsigned N = 8,
   parameter int unsigned W = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 mode,
   input  logic [N-1:0]         mask_in,
   input  logic [N*W-1:0]       src_in,
   input  logic [N*W-1:0]       dst_in,
   output logic                 busy,
   output logic                 done,
   output logic [len_bits(N)-1:0] count,
   output logic [N*W-1:0]       result
);

   localparam int unsigned IW = idx_bits(N);
   localparam int unsigned CW = len_bits(N);

   if (N < 2) begin : g_bad_n
      $error("vmce_unit: N must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("vmce_unit: W must be at least 1");
   end

   logic          load;
   logic          step_en;
   logic [IW-1:0] rd_idx;
   logic [IW-1:0] wr_idx;

   vmce_seq #(.N(N), .IW(IW), .CW(CW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode_in (mode),
      .mask_in (mask_in),
      .load    (load),
      .busy    (busy),
      .done    (done),
      .step_en (step_en),
      .rd_idx  (rd_idx),
      .wr_idx  (wr_idx),
      .count   (count)
   );

   vmce_store #(.N(N), .W(W), .IW(IW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .mode_in (mode),
      .src_in  (src_in),
      .dst_in  (dst_in),
      .step_en (step_en),
      .rd_idx  (rd_idx),
      .wr_idx  (wr_idx),
      .result  (result)
   );

endmodule

// File: rtl/vmce_unit_chk.sv
module vmce_unit_chk #(
   parameter int unsigned N  = 8,
   parameter int unsigned W  = 64,
   parameter int unsigned CW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [N-1:0]   mask_in,
   input logic           busy,
   input logic           done,
   input logic [CW-1:0]  count,
   input logic [N*W-1:0] result
);

   logic [N-1:0]  cap_mask;
   logic [CW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_mask <= '0;
         run_len  <= '0;
      end else if (start && !busy) begin
         cap_mask <= mask_in;
         run_len  <= '0;
      end else if (busy) begin
         run_len <= run_len + 1'b1;
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_run_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == CW'(N)));

   p_count_popcount_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (count == CW'($countones(cap_mask))));

   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(N));

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

endmodule

bind vmce_unit vmce_unit_chk #(.N(N), .W(W), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mask_in (mask_in),
   .busy    (busy),
   .done    (done),
   .count   (count),
   .result  (result)
);

// File: tb/sim_vmce_unit.sv
module sim_vmce_unit;

   localparam int unsigned N  = 6;
   localparam int unsigned W  = 12;
   localparam int unsigned NW = N * W;
   localparam int unsigned CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic [N-1:0]  mask_in = '0;
   logic [NW-1:0] src_in = '0;
   logic [NW-1:0] dst_in = '0;
   logic          busy;
   logic          done;
   logic [CW-1:0] count;
   logic [NW-1:0] result;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   vmce_unit #(.N(N), .W(W)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode    (mode),
      .mask_in (mask_in),
      .src_in  (src_in),
      .dst_in  (dst_in),
      .busy    (busy),
      .done    (done),
      .count   (count),
      .result  (result)
   );

   task automatic chk(input bit ok, input string tag, input logic [NW-1:0] act,
                      input logic [NW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] model(input bit md, input logic [N-1:0] m,
                                           input logic [NW-1:0] s, input logic [NW-1:0] d);
      logic [NW-1:0] r;
      int k = 0;
      r = md ? d : '0;
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            if (!md) r[k*W +: W] = s[i*W +: W];
            else     r[i*W +: W] = s[k*W +: W];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [NW-1:0] rand_vec();
      logic [NW-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      return v;
   endfunction

   task automatic run_op(input bit md, input logic [N-1:0] m, input logic [NW-1:0] s,
                         input logic [NW-1:0] d, input bit intrude);
      logic [NW-1:0] exp_r;
      logic [NW-1:0] held;
      int pop;
      int n;
      exp_r = model(md, m, s, d);
      pop = $countones(m);
      @(negedge clk);
      mode = md; mask_in = m; src_in = s; dst_in = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 4 * N) begin
         if (intrude && n == 2) begin
            start = 1'b1; mode = ~md; mask_in = ~m; src_in = rand_vec(); dst_in = rand_vec();
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      // R7: done seen at the (N+1)-th falling edge after acceptance
      chk(n == N + 1, "R7 done latency", NW'(n), NW'(N + 1));
      chk(!busy, "R7 busy low at done", NW'(busy), '0);
      chk(count == CW'(pop), "R4 count popcount", NW'(count), NW'(pop));
      if (!md) begin
         chk(result == exp_r, "R2 compress packing", result, exp_r);
         for (int j = pop; j < N; j++)
            chk(result[j*W +: W] == '0, "R3 zero above length", result, exp_r);
      end else begin
         chk(result == exp_r, "R5 expand placement", result, exp_r);
         for (int j = 0; j < N; j++)
            if (!m[j]) chk(result[j*W +: W] == d[j*W +: W], "R6 clear slot kept", result, d);
      end
      if (intrude) chk(result == exp_r, "R8 start during busy ignored", result, exp_r);
      held = result;
      @(negedge clk);
      chk(!done, "R7 done one cycle", NW'(done), '0);
      mask_in = ~mask_in; src_in = rand_vec();
      @(negedge clk);
      chk(result == held, "R8 result holds when idle", result, held);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [NW-1:0] s;
      logic [NW-1:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R1 reset flags", {busy, done}, '0);
      chk(count == '0, "R1 reset count", NW'(count), '0);
      chk(result == '0, "R1 reset result", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      s = rand_vec(); d = rand_vec();
      // R9 directed corner cases
      run_op(1'b0, '0, s, d, 1'b0);
      chk(result == '0 && count == '0, "R9 empty compress", result, '0);
      run_op(1'b1, '0, s, d, 1'b0);
      chk(result == d && count == '0, "R9 empty expand", result, d);
      run_op(1'b0, '1, s, d, 1'b0);
      chk(result == s && count == CW'(N), "R9 full compress identity", result, s);
      run_op(1'b1, '1, s, d, 1'b0);
      chk(result == s, "R9 full expand identity", result, s);
      run_op(1'b0, N'(1) << (N - 1), s, d, 1'b0);
      run_op(1'b1, N'(1) << (N - 1), s, d, 1'b0);
      run_op(1'b0, N'(6'b101101), s, d, 1'b1);
      run_op(1'b1, N'(6'b010011), s, d, 1'b1);

      for (int t = 0; t < 60; t++) begin
         run_op(1'($urandom), N'($urandom), rand_vec(), rand_vec(), (t % 7) == 3);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule